// File: doc/BRIEF.md
# Synchronous-Read Register File with Write Forwarding

This block holds the integer and floating-point architectural registers of an in-order core. Its storage is laid out to map onto block RAM, so every read is registered on the clock edge. Decode presents three operand addresses (A, B, C) one cycle before the operands are needed. Writeback supplies one write per cycle. A stall input freezes the operand addresses so that a held instruction keeps seeing its operands.

A write is visible to a reader on the same edge at which it is committed. The block does this by latching the write address and data, and by comparing them with each port's latched read address. On a match the latched write data replaces the array output. This hides the read-before-write behaviour of the RAM.

A debug agent can read any register. Its access is slipped onto port B in a cycle when that port is idle. The result comes back with a one-cycle valid pulse and is then held on a data output.

Top module: `regfile_sync`

## Requirements
- R1: After reset, `dbg_valid` is 0 and `dbg_data` is 0.
- R2: An address applied to a read port while `stall` is low returns, after the next rising edge, the contents of entry `{addr[5], addr[4:0]}`. Bit 5 = 0 selects the 32 integer registers and bit 5 = 1 selects the 32 floating-point registers.
- R3: Ports A, B and C read independently, each returning its own entry in the same cycle.
- R4: While `stall` is high, the address inputs are ignored and each port re-reads the address it latched last. Its output holds unless that entry is written.
- R5: A read of an entry on the same edge that writes it returns the newly written data on every port that addresses it. Ports that address other entries are not affected.
- R6: A write to an entry held by a stalled port appears on that port after the write edge.
- R7: A pending debug read is granted only in a cycle where `dec_valid && dec_b_used` is false. It waits for as long as that condition holds.
- R8: Debug numbering is as follows: `dbg_addr[6]` = 0 with `dbg_addr[4:0]` reads integer register 0x00–0x1F, and `dbg_addr[6]` = 1 reads floating-point register 0x40–0x5F. A request with `dbg_addr[5]` = 1 is ignored.
- R9: `dbg_valid` pulses for exactly one cycle, one cycle after the grant. `dbg_data` holds the returned value until the next debug read completes.
- R10: Ports A and C return correct data in cycles where the debug read borrows port B.
- R11: A debug request made while another is still pending is ignored. The pending read completes with its own address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dec_valid | input | 1 | Decode holds a valid instruction |
| dec_b_used | input | 1 | That instruction reads the B operand |
| stall | input | 1 | Reuse the latched read addresses |
| rd_addr_a | input | 6 | Operand A address |
| rd_addr_b | input | 6 | Operand B address |
| rd_addr_c | input | 6 | Operand C address |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 6 | Write address |
| wr_data | input | 64 | Write data |
| rd_data_a | output | 64 | Operand A data |
| rd_data_b | output | 64 | Operand B data |
| rd_data_c | output | 64 | Operand C data |
| dbg_req | input | 1 | Debug read request pulse |
| dbg_addr | input | 7 | Debug register number |
| dbg_valid | output | 1 | Debug data returned this cycle |
| dbg_data | output | 64 | Debug read data, held |

## Verification
The block is first tried with a full sweep of all 64 entries, with the three ports rotated by different offsets. This separates a wrong half select or a crossed port from a correct read. A second sweep writes and reads each entry on the same edge, with port C aimed at a neighbouring entry. It tells a working forwarding mux from one that fires on every write or on none. Stall windows with changing input addresses, with and without a write to a held entry, separate held addresses from ignored ones. Debug reads are issued across every GPR and FPR number, with port B busy, with a second request while one is pending, and with an out-of-range number. These cases tell apart the grant condition, the numbering, the single-cycle valid and the hold of the returned data.

// File: rtl/regfile_sync.sv
module regfile_sync #(
  parameter int DW = 64,
  parameter int NREG = 32,
  localparam int IW = $clog2(NREG),
  localparam int AW = IW + 1,
  localparam int DEPTH = 2 * NREG
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dec_valid,
  input  logic          dec_b_used,
  input  logic          stall,
  input  logic [AW-1:0] rd_addr_a,
  input  logic [AW-1:0] rd_addr_b,
  input  logic [AW-1:0] rd_addr_c,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data_a,
  output logic [DW-1:0] rd_data_b,
  output logic [DW-1:0] rd_data_c,
  input  logic          dbg_req,
  input  logic [AW:0]   dbg_addr,
  output logic          dbg_valid,
  output logic [DW-1:0] dbg_data
);

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] qa, qb, qc;
  logic [AW-1:0] pa_q, pb_q, pc_q, ib_q;
  logic [AW-1:0] ea, eb, ec, eib;
  logic          wv_q;
  logic [AW-1:0] wa_q;
  logic [DW-1:0] wd_q;
  logic          pend_q, grant, grant_q;
  logic [AW-1:0] dpa_q;
  logic [DW-1:0] hold_q;
  logic          dbg_ok;

  assign ea  = stall ? pa_q : rd_addr_a;
  assign ec  = stall ? pc_q : rd_addr_c;
  assign eib = stall ? ib_q : rd_addr_b;

  assign grant  = pend_q && !(dec_valid && dec_b_used);
  assign eb     = grant ? dpa_q : eib;
  assign dbg_ok = !dbg_addr[AW-1];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    qa <= mem[ea];
    qb <= mem[eb];
    qc <= mem[ec];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pa_q    <= '0;
      pb_q    <= '0;
      pc_q    <= '0;
      ib_q    <= '0;
      wv_q    <= 1'b0;
      wa_q    <= '0;
      wd_q    <= '0;
      pend_q  <= 1'b0;
      dpa_q   <= '0;
      grant_q <= 1'b0;
      hold_q  <= '0;
    end else begin
      pa_q    <= ea;
      pb_q    <= eb;
      pc_q    <= ec;
      ib_q    <= eib;
      wv_q    <= wr_en;
      wa_q    <= wr_addr;
      wd_q    <= wr_data;
      grant_q <= grant;
      if (grant) begin
        pend_q <= 1'b0;
      end else if (dbg_req && dbg_ok && !pend_q) begin
        pend_q <= 1'b1;
        dpa_q  <= {dbg_addr[AW], dbg_addr[IW-1:0]};
      end
      if (grant_q) hold_q <= rd_data_b;
    end
  end

  assign rd_data_a = (wv_q && wa_q == pa_q) ? wd_q : qa;
  assign rd_data_b = (wv_q && wa_q == pb_q) ? wd_q : qb;
  assign rd_data_c = (wv_q && wa_q == pc_q) ? wd_q : qc;

  assign dbg_valid = grant_q;
  assign dbg_data  = grant_q ? rd_data_b : hold_q;

endmodule

module regfile_sync_chk #(
  parameter int DW = 64,
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          dec_valid,
  input logic          dec_b_used,
  input logic          stall,
  input logic [AW-1:0] rd_addr_a,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [DW-1:0] wr_data,
  input logic [DW-1:0] rd_data_a,
  input logic          dbg_valid,
  input logic [DW-1:0] dbg_data
);

  logic up;
  always_ff @(posedge clk) begin
    if (rst) up <= 1'b0;
    else     up <= 1'b1;
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    up && stall && !wr_en |=> $stable(rd_data_a)); // R4

  AST_SAME_EDGE_FWD: assert property (@(posedge clk) disable iff (rst)
    !stall && wr_en && rd_addr_a == wr_addr |=> rd_data_a == $past(wr_data)); // R5

  AST_DBG_IDLE_B: assert property (@(posedge clk) disable iff (rst)
    up && dbg_valid |-> $past(!(dec_valid && dec_b_used))); // R7

  AST_DBG_PULSE: assert property (@(posedge clk) disable iff (rst)
    dbg_valid |=> !dbg_valid); // R9

  AST_DBG_HOLD: assert property (@(posedge clk) disable iff (rst)
    up && !dbg_valid |-> $stable(dbg_data)); // R9

endmodule

bind regfile_sync regfile_sync_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .dec_valid(dec_valid), .dec_b_used(dec_b_used),
  .stall(stall), .rd_addr_a(rd_addr_a), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .rd_data_a(rd_data_a), .dbg_valid(dbg_valid),
  .dbg_data(dbg_data)
);

// File: tb/tb_regfile_sync.sv
module tb_regfile_sync;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dec_valid = 1'b0, dec_b_used = 1'b0, stall = 1'b0;
  logic [5:0] rd_addr_a = '0, rd_addr_b = '0, rd_addr_c = '0;
  logic wr_en = 1'b0;
  logic [5:0] wr_addr = '0;
  logic [63:0] wr_data = '0;
  logic [63:0] rd_data_a, rd_data_b, rd_data_c;
  logic dbg_req = 1'b0;
  logic [6:0] dbg_addr = '0;
  logic dbg_valid;
  logic [63:0] dbg_data;

  logic [63:0] model [64];
  int total = 0, bad = 0;
  bit done = 0;

  regfile_sync dut (
    .clk(clk), .rst(rst), .dec_valid(dec_valid), .dec_b_used(dec_b_used),
    .stall(stall), .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b),
    .rd_addr_c(rd_addr_c), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_data_a(rd_data_a), .rd_data_b(rd_data_b), .rd_data_c(rd_data_c),
    .dbg_req(dbg_req), .dbg_addr(dbg_addr), .dbg_valid(dbg_valid),
    .dbg_data(dbg_data)
  );

  always #2 clk = ~clk;

  function automatic logic [63:0] pat(int i, int s);
    return (64'h9E3779B97F4A7C15 * 64'(i + 1 + 97 * s)) ^ 64'(s);
  endfunction

  task automatic tick();
    @(posedge clk);
    if (wr_en) model[wr_addr] = wr_data;
    #1;
  endtask

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #400000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      report();
    end
  end

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    tick();
    chk("R1 valid", 64'(dbg_valid), 64'd0);
    chk("R1 data", dbg_data, 64'd0);

    // fill every entry
    for (int i = 0; i < 64; i++) begin
      wr_en = 1'b1; wr_addr = 6'(i); wr_data = pat(i, 1);
      tick();
    end
    wr_en = 1'b0;

    // R2 / R3: rotated full sweep
    for (int i = 0; i < 64; i++) begin
      rd_addr_a = 6'(i); rd_addr_b = 6'((i + 1) % 64); rd_addr_c = 6'((i + 37) % 64);
      tick();
      chk("R2 port A", rd_data_a, model[i]);
      chk("R3 port B", rd_data_b, model[(i + 1) % 64]);
      chk("R3 port C", rd_data_c, model[(i + 37) % 64]);
    end

    // R5: same-edge write and read
    for (int i = 0; i < 64; i++) begin
      wr_en = 1'b1; wr_addr = 6'(i); wr_data = pat(i, 2);
      rd_addr_a = 6'(i); rd_addr_b = 6'(i); rd_addr_c = 6'((i + 1) % 64);
      tick();
      chk("R5 fwd A", rd_data_a, pat(i, 2));
      chk("R5 fwd B", rd_data_b, pat(i, 2));
      chk("R5 no fwd C", rd_data_c, model[(i + 1) % 64]);
    end
    wr_en = 1'b0;

    // R4 / R6: stall
    rd_addr_a = 6'd5; rd_addr_b = 6'd38; rd_addr_c = 6'd7;
    tick();
    stall = 1'b1;
    for (int k = 0; k < 3; k++) begin
      rd_addr_a = 6'(20 + k); rd_addr_b = 6'(50 + k); rd_addr_c = 6'(30 + k);
      tick();
      chk("R4 hold A", rd_data_a, model[5]);
      chk("R4 hold B", rd_data_b, model[38]);
      chk("R4 hold C", rd_data_c, model[7]);
    end
    wr_en = 1'b1; wr_addr = 6'd38; wr_data = 64'h0123_4567_89AB_CDEF;
    tick();
    wr_en = 1'b0;
    chk("R6 stalled write B", rd_data_b, 64'h0123_4567_89AB_CDEF);
    chk("R6 other A", rd_data_a, model[5]);
    tick();
    chk("R6 after write B", rd_data_b, 64'h0123_4567_89AB_CDEF);
    stall = 1'b0;
    rd_addr_a = 6'd20; rd_addr_b = 6'd50; rd_addr_c = 6'd30;
    tick();
    chk("R4 release A", rd_data_a, model[20]);
    chk("R4 release B", rd_data_b, model[50]);
    chk("R4 release C", rd_data_c, model[30]);

    // R8 / R9: debug sweep with port B idle
    for (int i = 0; i < 64; i++) begin
      dbg_req = 1'b1; dbg_addr = {i[5], 1'b0, i[4:0]};
      tick();
      dbg_req = 1'b0;
      chk("R9 not yet", 64'(dbg_valid), 64'd0);
      tick();
      chk("R9 valid", 64'(dbg_valid), 64'd1);
      chk("R8 data", dbg_data, model[i]);
      tick();
      chk("R9 pulse", 64'(dbg_valid), 64'd0);
      chk("R9 hold", dbg_data, model[i]);
    end

    // R7 / R10 / R11: port B busy, second request ignored
    dec_valid = 1'b1; dec_b_used = 1'b1;
    dbg_req = 1'b1; dbg_addr = 7'h43;
    tick();
    dbg_addr = 7'h09;
    tick();
    dbg_req = 1'b0;
    for (int k = 0; k < 4; k++) begin
      rd_addr_a = 6'(k); rd_addr_b = 6'(k + 10); rd_addr_c = 6'(k + 40);
      tick();
      chk("R7 wait", 64'(dbg_valid), 64'd0);
      chk("R7 B serves decode", rd_data_b, model[k + 10]);
      chk("R9 hold while waiting", dbg_data, model[63]);
    end
    dec_b_used = 1'b0;
    rd_addr_a = 6'd12; rd_addr_c = 6'd44;
    tick();
    chk("R7 grant", 64'(dbg_valid), 64'd1);
    chk("R11 pending address", dbg_data, model[35]);
    chk("R10 port A", rd_data_a, model[12]);
    chk("R10 port C", rd_data_c, model[44]);
    dec_b_used = 1'b1;
    tick();
    tick();
    chk("R11 second dropped", 64'(dbg_valid), 64'd0);
    chk("R11 hold", dbg_data, model[35]);

    // R7: invalid instruction frees port B
    dec_valid = 1'b0;
    dbg_req = 1'b1; dbg_addr = 7'h1F;
    tick();
    dbg_req = 1'b0;
    tick();
    chk("R7 free when no instr", 64'(dbg_valid), 64'd1);
    chk("R8 last GPR", dbg_data, model[31]);

    // R8: bit 5 set is ignored
    dbg_req = 1'b1; dbg_addr = 7'h25;
    tick();
    dbg_req = 1'b0;
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R8 ignored", 64'(dbg_valid), 64'd0);
      chk("R8 ignored data", dbg_data, model[31]);
    end

    done = 1;
    report();
  end
endmodule